// File: doc/BRIEF.md
# Half-Integer Clock Prescaler

This block divides an input clock by 2, 2.5, 3 or 3.5, picked by a 2-bit ratio code. Integer ratios come from a counter on the rising edge of the input clock. The half-integer ratios need a second path: a counter runs over two output periods (5 or 7 input cycles). One output pulse is launched from a rising-edge register and the next from a register on the falling edge. The two terms are ORed into the divided clock, so the output rising edges fall alternately on rising and falling input edges.

The ratio code is taken into the divider only when a restart happens. A restart is either a divider reset strobe or a global sync strobe, both synchronous to the input clock. A restart also brings the output phase back to a fixed starting point, so several dividers restarted by one sync stay aligned. A divider reset does not clear the programmed ratio: restarting with the same code gives the same ratio again. An asynchronous active-low reset returns the block to ratio 2.

Top module: `halfint_prescaler`

## Requirements
- R1: Code 2'b00 gives ratio 2, 2'b01 gives 2.5, 2'b10 gives 3 and 2'b11 gives 3.5. The time between consecutive rising edges of clk_div is then 4, 5, 6 or 7 input half-periods.
- R2: For ratios 2.5 and 3.5, each output period inside the two-period pattern has the same length, 5 or 7 half-periods. The output rising edges therefore alternate between rising and falling input edges.
- R3: clk_div stays high for 3 input half-periods at ratio 3 and for 2 input half-periods at every other ratio.
- R4: A change on ratio_sel with no restart has no effect on the output period.
- R5: A rising input edge that samples div_rst or sync high loads ratio_sel as the new ratio and restarts the counter. A restart with an unchanged code keeps the ratio.
- R6: clk_div is low from the first rising edge that samples a restart until the first output rise that follows it.
- R7: The first clk_div rising edge after a restart comes exactly one input clock period after the last rising edge that sampled the restart high.
- R8: While rst_n is low, clk_div is low and the ratio returns to code 2'b00, whatever ratio_sel holds. The first clk_div rise comes on the first rising input edge after rst_n is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to divide |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_sel | input | 2 | Ratio code, applied at the next restart |
| div_rst | input | 1 | Divider reset strobe (clears itself in the register that drives it) |
| sync | input | 1 | Global sync strobe for phase alignment |
| clk_div | output | 1 | Divided clock |

## Verification
The bench restarts the divider with each ratio code and times the output edges in input half-periods. Integer and half-integer ratios differ in period, in high time and in whether rises land on falling input edges. Random restarts vary the code, the source (reset or sync), the strobe length and the phase within the running pattern. These show that latency and the loaded ratio depend only on the last restart edge. Directed cases change the code with no restart, repeat a restart with the same code, and apply the asynchronous reset mid-run. They tell a latched ratio apart from one that follows the input, and a restart apart from a full reset.

// File: rtl/hip_pkg.sv
package hip_pkg;

   localparam int SEL_W = 2;

   typedef enum logic [SEL_W-1:0] {
      RATIO_2   = 2'b00,
      RATIO_2P5 = 2'b01,
      RATIO_3   = 2'b10,
      RATIO_3P5 = 2'b11
   } ratio_e;

   // input cycles per counter loop (two output periods for half ratios)
   function automatic int unsigned ratio_len(input logic [SEL_W-1:0] code);
      case (ratio_e'(code))
         RATIO_2:   return 2;
         RATIO_2P5: return 5;
         RATIO_3:   return 3;
         default:   return 7;
      endcase
   endfunction

   // counter value that launches the falling-edge pulse
   function automatic int unsigned ratio_mid(input logic [SEL_W-1:0] code);
      case (ratio_e'(code))
         RATIO_2P5: return 2;
         RATIO_3P5: return 3;
         default:   return 0;
      endcase
   endfunction

   // falling-edge path in use
   function automatic logic ratio_neg(input logic [SEL_W-1:0] code);
      return ratio_e'(code) != RATIO_2;
   endfunction

endpackage

// File: rtl/hip_ratio_latch.sv
module hip_ratio_latch #(
   parameter int                  CNT_W    = 3,
   parameter logic [1:0]          RST_CODE = 2'b00
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   restart,
   input  logic [1:0]             ratio_sel,
   output logic [CNT_W-1:0]       len,
   output logic [CNT_W-1:0]       mid,
   output logic                   neg_en
);

   logic [1:0] act_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       act_sel <= RST_CODE;
      else if (restart) act_sel <= ratio_sel;
   end

   always_comb begin
      len    = CNT_W'(hip_pkg::ratio_len(act_sel));
      mid    = CNT_W'(hip_pkg::ratio_mid(act_sel));
      neg_en = hip_pkg::ratio_neg(act_sel);
   end

   AST_RATIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !restart |=> $stable(act_sel)); // R4
   AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (act_sel == $past(ratio_sel))); // R5

endmodule

// File: rtl/hip_rise_cnt.sv
module hip_rise_cnt #(
   parameter int             CNT_W   = 3,
   parameter int             RST_LEN = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic [CNT_W-1:0]  len,
   input  logic [CNT_W-1:0]  mid,
   input  logic [CNT_W-1:0]  load_len,
   output logic              a_q,
   output logic              b_q,
   output logic              quiet_q
);

   generate
      if (RST_LEN < 2 || RST_LEN >= (1 << CNT_W)) begin : g_bad_len
         $error("hip_rise_cnt: RST_LEN out of range for CNT_W");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nx;

   always_comb begin
      if (cnt_q == len - 1'b1) cnt_nx = '0;
      else                     cnt_nx = cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= CNT_W'(RST_LEN - 1);
         a_q     <= 1'b0;
         b_q     <= 1'b0;
         quiet_q <= 1'b1;
      end else if (restart) begin
         cnt_q   <= load_len - 1'b1;
         a_q     <= 1'b0;
         b_q     <= 1'b0;
         quiet_q <= 1'b1;
      end else begin
         cnt_q   <= cnt_nx;
         a_q     <= (cnt_nx == '0);
         b_q     <= (cnt_nx == mid);
         quiet_q <= 1'b0;
      end
   end

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < len); // R1
   AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
      a_q |=> !a_q); // R3
   AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (!a_q && !b_q && quiet_q)); // R6
   AST_FIRST_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && $past(restart)) |=> a_q); // R7

endmodule

// File: rtl/hip_fall_stage.sv
module hip_fall_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic b_q,
   input  logic neg_en,
   output logic n_q
);

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) n_q <= 1'b0;
      else        n_q <= b_q & neg_en;
   end

   AST_NEG_OFF: assert property (@(negedge clk) disable iff (!rst_n)
      !neg_en |=> !n_q); // R3

endmodule

// File: rtl/halfint_prescaler.sv
module halfint_prescaler #(
   parameter int          CNT_W    = 3,
   parameter logic [1:0]  RST_CODE = 2'b00,
   parameter bit          GATE_NEG = 1'b1
) (
   input  logic       clk_in,
   input  logic       rst_n,
   input  logic [1:0] ratio_sel,
   input  logic       div_rst,
   input  logic       sync,
   output logic       clk_div
);

   localparam int RST_LEN = hip_pkg::ratio_len(RST_CODE);

   generate
      if (CNT_W < 3) begin : g_bad_w
         $error("halfint_prescaler: CNT_W must count to 7");
      end
   endgenerate

   logic             restart;
   logic [CNT_W-1:0] len;
   logic [CNT_W-1:0] mid;
   logic [CNT_W-1:0] load_len;
   logic             neg_en;
   logic             a_q;
   logic             b_q;
   logic             quiet_q;
   logic             n_q;

   assign restart  = div_rst | sync;
   assign load_len = CNT_W'(hip_pkg::ratio_len(ratio_sel));

   hip_ratio_latch #(.CNT_W(CNT_W), .RST_CODE(RST_CODE)) u_latch (
      .clk(clk_in), .rst_n(rst_n), .restart(restart), .ratio_sel(ratio_sel),
      .len(len), .mid(mid), .neg_en(neg_en)
   );

   hip_rise_cnt #(.CNT_W(CNT_W), .RST_LEN(RST_LEN)) u_cnt (
      .clk(clk_in), .rst_n(rst_n), .restart(restart), .len(len), .mid(mid),
      .load_len(load_len), .a_q(a_q), .b_q(b_q), .quiet_q(quiet_q)
   );

   hip_fall_stage u_fall (
      .clk(clk_in), .rst_n(rst_n), .b_q(b_q), .neg_en(neg_en), .n_q(n_q)
   );

   generate
      if (GATE_NEG) begin : g_gated
         assign clk_div = a_q | (n_q & ~quiet_q);
      end else begin : g_plain
         assign clk_div = a_q | n_q;
      end
   endgenerate

endmodule

// File: tb/halfint_prescaler_tb.sv
`timescale 1ns/1ps
module halfint_prescaler_tb;

   logic       clk_in = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] ratio_sel = 2'b00;
   logic       div_rst = 1'b0;
   logic       sync = 1'b0;
   logic       clk_div;
   int         checks = 0;
   int         failures = 0;

   always #4 clk_in = ~clk_in;

   halfint_prescaler u_dut (
      .clk_in(clk_in), .rst_n(rst_n), .ratio_sel(ratio_sel),
      .div_rst(div_rst), .sync(sync), .clk_div(clk_div)
   );

   function automatic int exp_period(input logic [1:0] s);
      return 4 + int'(s);
   endfunction

   function automatic int exp_high(input logic [1:0] s);
      return (s == 2'b10) ? 3 : 2;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int halves(input realtime d);
      return int'(d / 4.0);
   endfunction

   // measure high time and two periods starting from a rise at tr1
   task automatic measure(input realtime tr1, input logic [1:0] s, input string req);
      realtime tf, tr2, tr3;
      @(negedge clk_div) tf = $realtime;
      @(posedge clk_div) tr2 = $realtime;
      @(posedge clk_div) tr3 = $realtime;
      check(halves(tf - tr1) == exp_high(s), {req, " R3 high time"},
            halves(tf - tr1), exp_high(s));
      check(halves(tr2 - tr1) == exp_period(s), {req, " R1 period"},
            halves(tr2 - tr1), exp_period(s));
      check(halves(tr3 - tr2) == exp_period(s), {req, " R2 second period"},
            halves(tr3 - tr2), exp_period(s));
   endtask

   task automatic restart(input bit use_sync, input int hold, input logic [1:0] s,
                          input string req);
      realtime te, tr;
      @(posedge clk_in) #2;
      ratio_sel = s;
      if (use_sync) sync = 1'b1; else div_rst = 1'b1;
      for (int i = 0; i < hold; i++) begin
         @(posedge clk_in) te = $realtime;
      end
      #1;
      check(clk_div == 1'b0, {req, " R6 low after restart"}, int'(clk_div), 0);
      #1;
      sync = 1'b0;
      div_rst = 1'b0;
      @(posedge clk_div) tr = $realtime;
      check(halves(tr - te) == 2, {req, " R7 first rise latency"}, halves(tr - te), 2);
      measure(tr, s, req);
   endtask

   initial begin : main
      realtime tk, tr;
      void'($urandom(32'h5EED));
      #3;
      check(clk_div == 1'b0, "R8 low in reset", int'(clk_div), 0);
      repeat (3) @(posedge clk_in);
      #2 rst_n = 1'b1;
      @(posedge clk_in) tk = $realtime;
      @(posedge clk_div) tr = $realtime;
      // rise sampled at the same edge time as tk
      check(halves(tr - tk) == 0, "R8 first rise after release", halves(tr - tk), 0);
      measure(tr, 2'b00, "R8 default ratio");

      // directed: every code through the divider reset
      for (int c = 0; c < 4; c++) restart(1'b0, 1, 2'(c), "R1 directed");

      // R4: code change with no restart keeps ratio 3.5
      restart(1'b1, 1, 2'b11, "R5 sync load");
      @(posedge clk_in) #2 ratio_sel = 2'b00;
      @(posedge clk_div) tr = $realtime;
      measure(tr, 2'b11, "R4 code change ignored");
      // R5: restart with same code keeps ratio
      restart(1'b0, 2, 2'b11, "R5 same code");
      restart(1'b1, 3, 2'b01, "R5 held sync");

      // random restarts
      for (int k = 0; k < 24; k++) begin
         logic [1:0] s;
         bit         us;
         int         h;
         s  = 2'($urandom % 4);
         us = 1'($urandom % 2);
         h  = 1 + int'($urandom % 3);
         repeat (int'($urandom % 5)) @(posedge clk_in);
         restart(us, h, s, "R5 random");
      end

      // R8: asynchronous reset mid-run returns to ratio 2
      restart(1'b0, 1, 2'b11, "R8 before reset");
      @(posedge clk_in) #2 rst_n = 1'b0;
      #1;
      check(clk_div == 1'b0, "R8 low in mid-run reset", int'(clk_div), 0);
      repeat (2) @(posedge clk_in);
      #2 rst_n = 1'b1;
      @(posedge clk_div) tr = $realtime;
      measure(tr, 2'b00, "R8 ratio back to 2");

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : watchdog
      #(200000 * 8);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule